// File: doc/BRIEF.md
# ADC Result Parallel Read Port

This block sits between a conversion core model and a host that reads results over a parallel bus. The host starts a conversion with a strobe, which raises a busy flag. When the core reports completion with a done pulse and a 16-bit result, the block captures the result and drops busy in the same step. The falling edge of busy therefore tells the host that fresh data can be read, with no extra latency.

The host reads through active-low chip-select and read strobes. The bus is driven only while both strobes are low. Two live inputs shape what the host sees. A coding select gives either straight binary or twos complement, which differ only in the MSB. A swap select exchanges the two byte lanes so that an 8-bit host can fetch either byte from the same half of the bus. These selects act when the bus is read, so the same held result can be read back in any format.

Top module: `adc_par_read_port`

## Requirements
- R1: A conversion start seen while busy is low makes busy high from the next clock edge, and busy stays high until a done pulse is accepted.
- R2: A conversion start seen while busy is high is ignored: busy stays high and the held result does not change.
- R3: A done pulse seen while busy is high captures the core result, and from the next clock edge busy is low and the data-valid output is high. The new result can be read in that same cycle.
- R4: A done pulse seen while busy is low is ignored: the held result stays as it was.
- R5: With the coding select at 1, the bus carries the held result unchanged (straight binary). With it at 0, only bit 15 is inverted (twos complement).
- R6: With swap select at 0, result bits 15:8 appear on bus bits 15:8 and bits 7:0 on bus bits 7:0. With swap select at 1, the two bytes change places.
- R7: The output enable is high only while chip-select and read are both low. While it is low, the data bus reads as all zeros.
- R8: Changes to the coding and swap selects reformat the held result on the bus in the same cycle, with no clock edge needed.
- R9: A synchronous reset clears busy, data-valid and the held result to zero.
- R10: An accepted conversion start clears data-valid from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| convStart | input | 1 | Host conversion-start strobe |
| coreDone | input | 1 | Core completion pulse |
| coreResult | input | 16 | Core result, valid with coreDone |
| binSel | input | 1 | 1 = straight binary, 0 = twos complement |
| swapSel | input | 1 | 1 = exchange the byte lanes |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| busy | output | 1 | Conversion in progress |
| dataOut | output | 16 | Formatted result bus |
| dataOe | output | 1 | Bus output enable |
| dataValid | output | 1 | A result is held and no conversion is pending |

## Verification
A wrong busy state shows one cycle after the stimulus. Busy either fails to rise on an idle start, falls without a done pulse, or lets a stray done pulse overwrite the held result, and the next read shows that wrong value. Coding or lane-routing faults are visible on the bus as soon as the strobes go low, in the same cycle, so each of the four select combinations is read against the held word. Results with asymmetric bytes and MSB set or clear expose each of these faults.

// File: rtl/adc_prp_pkg.sv
package adc_prp_pkg;
  typedef struct packed {
    logic latch;
    logic invalidate;
  } prpStrobes_t;
endpackage

// File: rtl/adc_prp_ctrl.sv
module adc_prp_ctrl
  import adc_prp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        convStart,
  input  logic        coreDone,
  output logic        busy,
  output prpStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_CONV} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext          = state;
    strobes.latch      = 1'b0;
    strobes.invalidate = 1'b0;
    case (state)
      ST_IDLE: if (convStart) begin
        stateNext          = ST_CONV;
        strobes.invalidate = 1'b1;
      end
      ST_CONV: if (coreDone) begin
        stateNext     = ST_IDLE;
        strobes.latch = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state == ST_CONV);
endmodule

// File: rtl/adc_prp_datapath.sv
module adc_prp_datapath
  import adc_prp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  prpStrobes_t       strobes,
  input  logic [DATA_W-1:0] coreResult,
  input  logic              binSel,
  input  logic              swapSel,
  input  logic              csN,
  input  logic              rdN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dataValid
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] heldResult;
  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] routed;
  logic              heldValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldResult <= '0;
      heldValid  <= 1'b0;
    end else begin
      if (strobes.latch) begin
        heldResult <= coreResult;
        heldValid  <= 1'b1;
      end else if (strobes.invalidate) begin
        heldValid  <= 1'b0;
      end
    end
  end

  assign coded = {heldResult[DATA_W-1] ^ ~binSel, heldResult[DATA_W-2:0]};

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    assign routed[lane*LANE_W +: LANE_W] = swapSel
      ? coded[(NUM_LANES-1-lane)*LANE_W +: LANE_W]
      : coded[lane*LANE_W +: LANE_W];
  end

  assign dataOe    = ~csN & ~rdN;
  assign dataOut   = dataOe ? routed : '0;
  assign dataValid = heldValid;
endmodule

// File: rtl/adc_par_read_port.sv
module adc_par_read_port
  import adc_prp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              convStart,
  input  logic              coreDone,
  input  logic [DATA_W-1:0] coreResult,
  input  logic              binSel,
  input  logic              swapSel,
  input  logic              csN,
  input  logic              rdN,
  output logic              busy,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dataValid
);
  prpStrobes_t strobes;

  adc_prp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .convStart(convStart), .coreDone(coreDone),
    .busy(busy), .strobes(strobes)
  );

  adc_prp_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .coreResult(coreResult),
    .binSel(binSel), .swapSel(swapSel), .csN(csN), .rdN(rdN),
    .dataOut(dataOut), .dataOe(dataOe), .dataValid(dataValid)
  );
endmodule

// File: rtl/adc_prp_chk.sv
module adc_prp_chk #(
  parameter int DATA_W = 16
)(
  input logic              clk,
  input logic              rst,
  input logic              convStart,
  input logic              coreDone,
  input logic              binSel,
  input logic              swapSel,
  input logic              csN,
  input logic              rdN,
  input logic              busy,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              dataValid
);
  // R1
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && convStart) |=> busy);
  // R1
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !coreDone) |=> busy);
  // R2
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && convStart && !coreDone) |=> (busy && !dataValid));
  // R3
  done_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && coreDone) |=> (!busy && dataValid));
  // R3
  busy_fall_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> dataValid);
  // R7
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dataOe |-> (dataOut == '0));
  // R7
  oe_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> (!csN && !rdN));
  // R8
  held_word_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && dataOe && $past(dataOe)
     && $stable(binSel) && $stable(swapSel)) |-> $stable(dataOut));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !dataValid));
  // R10
  start_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && convStart) |=> !dataValid);
endmodule

bind adc_par_read_port adc_prp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .convStart(convStart), .coreDone(coreDone),
  .binSel(binSel), .swapSel(swapSel), .csN(csN), .rdN(rdN),
  .busy(busy), .dataOut(dataOut), .dataOe(dataOe), .dataValid(dataValid)
);

// File: tb/sim_adc_par_read_port.sv
`timescale 1ns/1ps
module sim_adc_par_read_port;
  logic        clk = 1'b0;
  logic        rst, convStart, coreDone, binSel, swapSel, csN, rdN;
  logic [15:0] coreResult;
  logic        busy, dataOe, dataValid;
  logic [15:0] dataOut;
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  adc_par_read_port u0 (
    .clk(clk), .rst(rst), .convStart(convStart), .coreDone(coreDone),
    .coreResult(coreResult), .binSel(binSel), .swapSel(swapSel),
    .csN(csN), .rdN(rdN), .busy(busy), .dataOut(dataOut),
    .dataOe(dataOe), .dataValid(dataValid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(logic [15:0] v, logic b, logic s);
    logic [15:0] c;
    c = {v[15] ^ ~b, v[14:0]};
    return s ? {c[7:0], c[15:8]} : c;
  endfunction

  task automatic readCheck(string tag, logic [15:0] held, logic b, logic s);
    @(negedge clk);
    binSel = b; swapSel = s; csN = 1'b0; rdN = 1'b0;
    #1;
    check({tag, " oe"}, {31'd0, dataOe}, 32'd1);
    check({tag, " data"}, {16'd0, dataOut}, {16'd0, expWord(held, b, s)});
    csN = 1'b1;
    #1;
    check("R7 oe off", {31'd0, dataOe}, 32'd0);
    check("R7 bus zero", {16'd0, dataOut}, 32'd0);
    rdN = 1'b1;
  endtask

  task automatic convert(logic [15:0] v);
    @(negedge clk);
    convStart = 1'b1;
    @(posedge clk); #1;
    check("R1 busy up", {31'd0, busy}, 32'd1);
    check("R10 valid cleared", {31'd0, dataValid}, 32'd0);
    @(negedge clk);
    convStart = 1'b0; coreDone = 1'b1; coreResult = v;
    @(posedge clk); #1;
    check("R3 busy down", {31'd0, busy}, 32'd0);
    check("R3 valid", {31'd0, dataValid}, 32'd1);
    @(negedge clk);
    coreDone = 1'b0; coreResult = 16'hDEAD;
  endtask

  task automatic testReset();
    rst = 1'b1; convStart = 0; coreDone = 0; coreResult = 0;
    binSel = 1; swapSel = 0; csN = 1; rdN = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R9 busy", {31'd0, busy}, 32'd0);
    check("R9 valid", {31'd0, dataValid}, 32'd0);
    readCheck("R9 result binary", 16'h0000, 1'b1, 1'b0);
    readCheck("R9 result twos", 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic testFormats(logic [15:0] v);
    convert(v);
    readCheck("R5 binary R6 noswap", v, 1'b1, 1'b0);
    readCheck("R5 twos R6 noswap", v, 1'b0, 1'b0);
    readCheck("R6 swap binary", v, 1'b1, 1'b1);
    readCheck("R6 swap twos", v, 1'b0, 1'b1);
  endtask

  task automatic testLiveSelects();
    convert(16'hA55A);
    @(negedge clk);
    csN = 0; rdN = 0; binSel = 1; swapSel = 0;
    #1 check("R8 first", {16'd0, dataOut}, 32'h0000A55A);
    swapSel = 1;
    #1 check("R8 swap live", {16'd0, dataOut}, 32'h00005AA5);
    binSel = 0;
    #1 check("R8 code live", {16'd0, dataOut}, 32'h00005A25);
    csN = 1; rdN = 1; binSel = 1; swapSel = 0;
  endtask

  task automatic testStartWhileBusy();
    @(negedge clk); convStart = 1;
    @(negedge clk); coreResult = 16'h7777;
    @(posedge clk); #1;
    check("R2 busy held", {31'd0, busy}, 32'd1);
    check("R2 valid low", {31'd0, dataValid}, 32'd0);
    @(negedge clk); convStart = 0; coreDone = 1; coreResult = 16'h1357;
    @(posedge clk); #1;
    check("R3 busy down after ignore", {31'd0, busy}, 32'd0);
    @(negedge clk); coreDone = 0;
    readCheck("R2 result from done", 16'h1357, 1'b1, 1'b0);
  endtask

  task automatic testDoneIdle();
    convert(16'h2468);
    @(negedge clk); coreDone = 1; coreResult = 16'hFFFF;
    @(posedge clk); #1;
    check("R4 busy stays low", {31'd0, busy}, 32'd0);
    @(negedge clk); coreDone = 0;
    readCheck("R4 held unchanged", 16'h2468, 1'b1, 1'b0);
  endtask

  task automatic testPartialStrobes();
    @(negedge clk); csN = 0; rdN = 1;
    #1 check("R7 cs only", {31'd0, dataOe}, 32'd0);
    check("R7 cs only bus", {16'd0, dataOut}, 32'd0);
    csN = 1; rdN = 0;
    #1 check("R7 rd only", {31'd0, dataOe}, 32'd0);
    rdN = 1;
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    testReset();
    testFormats(16'h1234);
    testFormats(16'h8001);
    testFormats(16'hFFFF);
    testFormats(16'h0000);
    testLiveSelects();
    testStartWhileBusy();
    testDoneIdle();
    testPartialStrobes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule